// File: doc/BRIEF.md
# Pulse and Tone Dial Sequencer

This block sits between a keypad front end and the line interface of a telephone. It receives validated key events and turns each one into line signalling. In pulse mode a digit becomes a train of timed line breaks: during each break the dial-pulse output pulls the line low, and during each make the shunt control is driven low. After the train comes a fixed inter-digit gap. Two recall keys open the line for a short or a long timed break. A pause key holds the sequencer busy for two seconds and does nothing else. Keys that arrive while signalling is under way wait in a small FIFO and are sent in order.

The block also tracks whether the current call signals by pulses or by tones. A three-level strap sets the default. With the strap low or high, the call starts in pulse mode, and each level has its own make/break ratio. With the strap open, the call uses tones only. Star switches a pulse call to tone mode. A recall key or going on-hook switches it back, unless the strap locks tone mode. In tone mode every digit, star or hash produces a one-cycle strobe carrying the key code to an external tone generator, followed by a fixed tone slot. All timing counts a one-millisecond tick input.

Top module: `dial_sequencer`

## Requirements
- R1: Synchronous reset returns the block to idle. After reset `dp_pull`=0, `shunt_n`=1, `busy`=0 and `tone_strobe`=0, and `tone_mode` equals 1 only when the strap is open.
- R2: The strap encoding is 00 for low, 01 for high, and 1x for open. With strap 00 each pulse has a 60 ms break and a 40 ms make. With strap 01 each pulse has a 66 ms break and a 33 ms make. A phase of M ms lasts exactly M ticks: it ends on the clock edge that registers the M-th tick after the phase began.
- R3: In pulse mode, key code N (1 to 9) produces N pulses and key code 0 produces 10. Each pulse is a break followed by a make. `dp_pull` is 1 during breaks only, and `shunt_n` is 0 during makes only.
- R4: After the last make of a digit, an 800 ms inter-digit gap follows. During the gap both line outputs are idle and `busy` stays 1.
- R5: Key code 12 asserts `dp_pull` for 100 ms and key code 13 asserts it for 600 ms. Both keys return a temporary tone call to pulse mode when they are taken from the queue.
- R6: Key code 14 holds `busy` for 2000 ms with no line activity.
- R7: With strap 00 or 01, star (code 10) taken from the queue in pulse mode sets `tone_mode` and produces no signalling.
- R8: With the strap open, `tone_mode` is always 1 and no digit ever produces break pulses, even after a recall key.
- R9: While `off_hook`=0, the queue is flushed, any activity is aborted on the next edge, new keys are ignored, and `tone_mode` returns to the strap default.
- R10: Keys are queued in order, up to the FIFO depth (8). A key that arrives while the FIFO is full is discarded, and so is code 15.
- R11: In tone mode a digit, star (10) or hash (11) raises `tone_strobe` for exactly one cycle with the code on `tone_code`, then holds `busy` for a 100 ms slot. Hash in pulse mode is discarded.
- R12: `busy` is 1 exactly while a pulse train with its gap, a flash, a pause or a tone slot is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| off_hook | input | 1 | 1 while the handset is off-hook |
| strap_mode | input | 2 | Mode strap: 00 low, 01 high, 1x open |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| key_valid | input | 1 | Key event valid this cycle |
| key_code | input | 4 | 0-9 digits, 10 star, 11 hash, 12 short recall, 13 long recall, 14 pause |
| dp_pull | output | 1 | 1 = dial-pulse open drain pulls the line low |
| shunt_n | output | 1 | Shunt control, low shorts the line during makes |
| tone_mode | output | 1 | 1 while the call signals by tones |
| tone_strobe | output | 1 | One-cycle request to the tone generator |
| tone_code | output | 4 | Key code that goes with `tone_strobe` |
| busy | output | 1 | Signalling activity in progress |

## Verification
Two things can happen on the same clock edge. A new key can be pushed while the sequencer pops the head of the queue, and a key can arrive at the edge where the FIFO is full and the head is being popped. The bench provokes both by pressing keys in bursts while a digit finishes and by overfilling the queue during a long train. A behavioural queue model judges each case: it decides fullness before that edge's pop and compares every output on every cycle. The bench also lets a millisecond tick fall on the edge where a phase starts. It checks that this tick is not counted by measuring the lengths of the break, make, flash, pause and slot phases against the tick count.

// File: rtl/dial_pkg.sv
// Shared types and key codes for the dial sequencer.
// Assumes a 4-bit key code coming from the keypad front end.
package dial_pkg;
    localparam int KEY_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_MAKE,
        ST_GAP,
        ST_FLASH,
        ST_PAUSE,
        ST_TONE
    } dial_state_t;

    localparam logic [KEY_W-1:0] KEY_DIGIT_MAX = 4'd9;
    localparam logic [KEY_W-1:0] KEY_STAR      = 4'd10;
    localparam logic [KEY_W-1:0] KEY_HASH      = 4'd11;
    localparam logic [KEY_W-1:0] KEY_RECALL_S  = 4'd12;
    localparam logic [KEY_W-1:0] KEY_RECALL_L  = 4'd13;
    localparam logic [KEY_W-1:0] KEY_PAUSE     = 4'd14;
    localparam logic [KEY_W-1:0] KEY_NONE      = 4'd15;

    localparam logic [1:0] STRAP_HIGH = 2'b01;
endpackage

// File: rtl/dial_fifo.sv
// Key queue: a circular buffer with a flush.
// Assumes push is refused when full, judged on the state before the edge.
// Pop and flush are honoured in the same cycle as they are requested.
module dial_fifo #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    // Accept and release decisions.
    always_comb begin
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
    end

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign dout  = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full); // R10
    AST_FIFO_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R9
endmodule

// File: rtl/dial_mode.sv
// Tracks whether the current call signals by pulses or by tones.
// Assumes set and clear are never requested together (the engine pops one key per cycle).
module dial_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic off_hook,
    input  logic strap_open,
    input  logic set_tone,
    input  logic clr_tone,
    output logic tone_mode
);
    logic temp_tone;

    // Temporary tone flag: star sets it, recall and on-hook clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || !off_hook) temp_tone <= 1'b0;
        else if (clr_tone)       temp_tone <= 1'b0;
        else if (set_tone)       temp_tone <= 1'b1;
    end

    assign tone_mode = strap_open || temp_tone;

    AST_ONHOOK_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
        !off_hook |=> (tone_mode == strap_open || !$stable(strap_open))); // R9
    AST_RECALL_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tone && off_hook) |=> (tone_mode == strap_open || !$stable(strap_open))); // R5
endmodule

// File: rtl/dial_engine.sv
// Signalling engine: takes one queued key at a time and times the line phases
// (break, make, gap, flash, pause, tone slot) in millisecond ticks.
// Assumes ms_tick is a single-cycle pulse; a tick on the edge a phase starts is not counted.
module dial_engine
    import dial_pkg::*;
#(
    parameter int BREAK_LO_MS = 60,
    parameter int MAKE_LO_MS  = 40,
    parameter int BREAK_HI_MS = 66,
    parameter int MAKE_HI_MS  = 33,
    parameter int GAP_MS      = 800,
    parameter int RECALL_S_MS = 100,
    parameter int RECALL_L_MS = 600,
    parameter int PAUSE_MS    = 2000,
    parameter int TONE_MS     = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             off_hook,
    input  logic             ms_tick,
    input  logic [1:0]       strap_mode,
    input  logic             tone_mode,
    input  logic             q_empty,
    input  logic [KEY_W-1:0] q_data,
    output logic             q_pop,
    output logic             set_tone,
    output logic             clr_tone,
    output logic             dp_pull,
    output logic             shunt_n,
    output logic             busy,
    output logic             tone_strobe,
    output logic [KEY_W-1:0] tone_code
);
    localparam int CNT_W = $clog2(PAUSE_MS + GAP_MS + RECALL_L_MS + TONE_MS + 2);
    localparam logic [CNT_W-1:0] L_BRK_LO = CNT_W'(BREAK_LO_MS);
    localparam logic [CNT_W-1:0] L_MK_LO  = CNT_W'(MAKE_LO_MS);
    localparam logic [CNT_W-1:0] L_BRK_HI = CNT_W'(BREAK_HI_MS);
    localparam logic [CNT_W-1:0] L_MK_HI  = CNT_W'(MAKE_HI_MS);
    localparam logic [CNT_W-1:0] L_GAP    = CNT_W'(GAP_MS);
    localparam logic [CNT_W-1:0] L_RC_S   = CNT_W'(RECALL_S_MS);
    localparam logic [CNT_W-1:0] L_RC_L   = CNT_W'(RECALL_L_MS);
    localparam logic [CNT_W-1:0] L_PAUSE  = CNT_W'(PAUSE_MS);
    localparam logic [CNT_W-1:0] L_TONE   = CNT_W'(TONE_MS);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    dial_state_t      st;
    logic [CNT_W-1:0] cnt;
    logic [3:0]       pulses_left;
    logic [CNT_W-1:0] brk_len, mk_len;
    logic             is_digit, tone_key;

    // Break and make lengths follow the strap level.
    always_comb begin
        brk_len = (strap_mode == STRAP_HIGH) ? L_BRK_HI : L_BRK_LO;
        mk_len  = (strap_mode == STRAP_HIGH) ? L_MK_HI  : L_MK_LO;
    end

    // Queue pop and mode requests for the key at the head.
    always_comb begin
        q_pop    = off_hook && (st == ST_IDLE) && !q_empty;
        is_digit = (q_data <= KEY_DIGIT_MAX);
        tone_key = tone_mode && (is_digit || q_data == KEY_STAR || q_data == KEY_HASH);
        set_tone = q_pop && (q_data == KEY_STAR) && !tone_mode;
        clr_tone = q_pop && (q_data == KEY_RECALL_S || q_data == KEY_RECALL_L);
    end

    // Phase sequencer with millisecond down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            cnt         <= '0;
            pulses_left <= '0;
            tone_strobe <= 1'b0;
            tone_code   <= '0;
        end else begin
            tone_strobe <= 1'b0;
            if (!off_hook) begin
                st          <= ST_IDLE;
                cnt         <= '0;
                pulses_left <= '0;
            end else if (q_pop) begin
                if (tone_key) begin
                    tone_strobe <= 1'b1;
                    tone_code   <= q_data;
                    st          <= ST_TONE;
                    cnt         <= L_TONE;
                end else if (is_digit) begin
                    st          <= ST_BREAK;
                    cnt         <= brk_len;
                    pulses_left <= (q_data == '0) ? 4'd10 : q_data;
                end else if (q_data == KEY_RECALL_S) begin
                    st  <= ST_FLASH;
                    cnt <= L_RC_S;
                end else if (q_data == KEY_RECALL_L) begin
                    st  <= ST_FLASH;
                    cnt <= L_RC_L;
                end else if (q_data == KEY_PAUSE) begin
                    st  <= ST_PAUSE;
                    cnt <= L_PAUSE;
                end
            end else if (st != ST_IDLE && ms_tick) begin
                if (cnt > ONE) begin
                    cnt <= cnt - ONE;
                end else begin
                    case (st)
                        ST_BREAK: begin
                            st  <= ST_MAKE;
                            cnt <= mk_len;
                        end
                        ST_MAKE: begin
                            if (pulses_left == 4'd1) begin
                                st  <= ST_GAP;
                                cnt <= L_GAP;
                            end else begin
                                pulses_left <= pulses_left - 4'd1;
                                st          <= ST_BREAK;
                                cnt         <= brk_len;
                            end
                        end
                        default: begin
                            st  <= ST_IDLE;
                            cnt <= '0;
                        end
                    endcase
                end
            end
        end
    end

    assign dp_pull = (st == ST_BREAK) || (st == ST_FLASH);
    assign shunt_n = (st != ST_MAKE);
    assign busy    = (st != ST_IDLE);

    AST_LINE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_pull && !shunt_n)); // R3
    AST_ONHOOK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !off_hook |=> (!busy && !dp_pull && shunt_n)); // R9
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tone_strobe |=> !tone_strobe); // R11
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tone_strobe |-> busy); // R11
    AST_NO_PULSE_IN_TONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_BREAK) && ($past(st) == ST_IDLE)) |-> !$past(tone_mode)); // R8
endmodule

// File: rtl/dial_sequencer.sv
// Top of the pulse and tone dial sequencer: key queue, mode tracker, signalling engine.
// Assumes key events are already debounced and one cycle long, and ms_tick is one cycle per ms.
module dial_sequencer
    import dial_pkg::*;
#(
    parameter int QUEUE_DEPTH = 8,
    parameter int BREAK_LO_MS = 60,
    parameter int MAKE_LO_MS  = 40,
    parameter int BREAK_HI_MS = 66,
    parameter int MAKE_HI_MS  = 33,
    parameter int GAP_MS      = 800,
    parameter int RECALL_S_MS = 100,
    parameter int RECALL_L_MS = 600,
    parameter int PAUSE_MS    = 2000,
    parameter int TONE_MS     = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       off_hook,
    input  logic [1:0] strap_mode,
    input  logic       ms_tick,
    input  logic       key_valid,
    input  logic [3:0] key_code,
    output logic       dp_pull,
    output logic       shunt_n,
    output logic       tone_mode,
    output logic       tone_strobe,
    output logic [3:0] tone_code,
    output logic       busy
);
    logic             q_push, q_pop, q_empty, q_full;
    logic [KEY_W-1:0] q_data;
    logic             set_tone, clr_tone;

    // Keys are queued only off-hook and only with a defined code.
    assign q_push = key_valid && off_hook && (key_code != KEY_NONE);

    dial_fifo #(.WIDTH(KEY_W), .DEPTH(QUEUE_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!off_hook),
        .push  (q_push),
        .din   (key_code),
        .pop   (q_pop),
        .dout  (q_data),
        .empty (q_empty),
        .full  (q_full)
    );

    dial_mode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .off_hook   (off_hook),
        .strap_open (strap_mode[1]),
        .set_tone   (set_tone),
        .clr_tone   (clr_tone),
        .tone_mode  (tone_mode)
    );

    dial_engine #(
        .BREAK_LO_MS (BREAK_LO_MS),
        .MAKE_LO_MS  (MAKE_LO_MS),
        .BREAK_HI_MS (BREAK_HI_MS),
        .MAKE_HI_MS  (MAKE_HI_MS),
        .GAP_MS      (GAP_MS),
        .RECALL_S_MS (RECALL_S_MS),
        .RECALL_L_MS (RECALL_L_MS),
        .PAUSE_MS    (PAUSE_MS),
        .TONE_MS     (TONE_MS)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .off_hook    (off_hook),
        .ms_tick     (ms_tick),
        .strap_mode  (strap_mode),
        .tone_mode   (tone_mode),
        .q_empty     (q_empty),
        .q_data      (q_data),
        .q_pop       (q_pop),
        .set_tone    (set_tone),
        .clr_tone    (clr_tone),
        .dp_pull     (dp_pull),
        .shunt_n     (shunt_n),
        .busy        (busy),
        .tone_strobe (tone_strobe),
        .tone_code   (tone_code)
    );

    AST_FULL_QUEUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && off_hook && !q_pop) |=> q_full); // R10
endmodule

// File: tb/dial_sequencer_tb.sv
// Bench for dial_sequencer: a behavioural queue model is stepped on every edge and
// compared with the outputs on every falling edge; phase lengths are measured as well.
module dial_sequencer_tb;
    localparam int DEPTH = 8;
    localparam int TPM   = 4;   // clocks per ms tick

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       off_hook = 1'b1;
    logic [1:0] strap_mode = 2'b00;
    logic       ms_tick = 1'b0;
    logic       key_valid = 1'b0;
    logic [3:0] key_code = 4'd0;
    logic       dp_pull, shunt_n, tone_mode, tone_strobe, busy;
    logic [3:0] tone_code;

    always #2 clk = ~clk;

    dial_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .off_hook(off_hook), .strap_mode(strap_mode),
        .ms_tick(ms_tick), .key_valid(key_valid), .key_code(key_code),
        .dp_pull(dp_pull), .shunt_n(shunt_n), .tone_mode(tone_mode),
        .tone_strobe(tone_strobe), .tone_code(tone_code), .busy(busy)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit compare_on = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_len(input string req, input int act, input int ms);
        checks++;
        if (act < TPM * ms - (TPM - 1) || act > TPM * ms) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d cycles", req, act,
                     TPM * ms - (TPM - 1), TPM * ms);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Millisecond tick: one cycle in every TPM.
    int tick_div = 0;
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % TPM;
        ms_tick <= (tick_div == 0);
    end

    // ---------------- behavioural model ----------------
    int q[$];
    int m_st = 0;      // 0 idle, 1 break, 2 make, 3 gap, 4 flash, 5 pause, 6 tone
    int m_rem = 0;
    int m_pulses = 0;
    bit m_temp = 0;
    bit m_strobe = 0;
    int m_code = 0;

    function automatic int brk_ms();
        return (strap_mode == 2'b01) ? 66 : 60;
    endfunction
    function automatic int mk_ms();
        return (strap_mode == 2'b01) ? 33 : 40;
    endfunction
    function automatic bit m_tone();
        return strap_mode[1] || m_temp;
    endfunction

    always @(posedge clk) begin
        bit full_before;
        int k;
        full_before = (q.size() >= DEPTH);
        m_strobe = 1'b0;
        if (!rst_n) begin
            q.delete(); m_st = 0; m_rem = 0; m_temp = 0; m_code = 0;
        end else if (!off_hook) begin
            q.delete(); m_st = 0; m_temp = 0;
        end else begin
            if (m_st == 0) begin
                if (q.size() > 0) begin
                    k = q.pop_front();
                    if (m_tone() && (k <= 11)) begin
                        m_strobe = 1'b1; m_code = k; m_st = 6; m_rem = 100;
                    end else if (k <= 9) begin
                        m_st = 1; m_rem = brk_ms(); m_pulses = (k == 0) ? 10 : k;
                    end else if (k == 10) begin
                        m_temp = 1'b1;
                    end else if (k == 12 || k == 13) begin
                        m_temp = 1'b0; m_st = 4; m_rem = (k == 12) ? 100 : 600;
                    end else if (k == 14) begin
                        m_st = 5; m_rem = 2000;
                    end
                end
            end else if (ms_tick) begin
                if (m_rem > 1) m_rem--;
                else if (m_st == 1) begin m_st = 2; m_rem = mk_ms(); end
                else if (m_st == 2) begin
                    if (m_pulses == 1) begin m_st = 3; m_rem = 800; end
                    else begin m_pulses--; m_st = 1; m_rem = brk_ms(); end
                end else m_st = 0;
            end
            if (key_valid && key_code != 4'd15 && !full_before) q.push_back(int'(key_code));
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        cycles++;
        if (compare_on) begin
            check("R3 dp_pull", int'(dp_pull), int'(m_st == 1 || m_st == 4));
            check("R3 shunt_n", int'(shunt_n), int'(m_st != 2));
            check("R12 busy", int'(busy), int'(m_st != 0));
            check("R7 tone_mode", int'(tone_mode), int'(m_tone()));
            check("R11 tone_strobe", int'(tone_strobe), int'(m_strobe));
            if (m_strobe) check("R11 tone_code", int'(tone_code), m_code);
        end
        if (cycles > 190000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
            finish_run();
        end
    end

    // Output monitor measuring phase lengths and counting events.
    int dp_run = 0, dp_last = 0, dp_rises = 0;
    int sh_run = 0, sh_last = 0;
    int bz_run = 0, bz_last = 0;
    int strobes = 0, last_code = 0;
    bit dp_prev = 0;
    always @(negedge clk) begin
        if (dp_pull && !dp_prev) dp_rises++;
        dp_prev = dp_pull;
        if (dp_pull) dp_run++; else if (dp_run != 0) begin dp_last = dp_run; dp_run = 0; end
        if (!shunt_n) sh_run++; else if (sh_run != 0) begin sh_last = sh_run; sh_run = 0; end
        if (busy) bz_run++; else if (bz_run != 0) begin bz_last = bz_run; bz_run = 0; end
        if (tone_strobe) begin strobes++; last_code = int'(tone_code); end
    end

    task automatic clear_mon();
        dp_rises = 0; dp_last = 0; sh_last = 0; bz_last = 0; strobes = 0; last_code = 0;
    endtask

    task automatic press(input int code);
        @(negedge clk);
        key_valid = 1'b1; key_code = 4'(code);
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_st != 0 || q.size() != 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R1 dp_pull", int'(dp_pull), 0);
        check("R1 shunt_n", int'(shunt_n), 1);
        check("R1 busy", int'(busy), 0);
        check("R1 tone_mode", int'(tone_mode), 0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        repeat (4) @(negedge clk);

        // Digit 2, strap low.
        clear_mon(); press(2); wait_idle();
        check("R3 pulses for 2", dp_rises, 2);
        check_len("R2 break low", dp_last, 60);
        check_len("R2 make low", sh_last, 40);
        check_len("R4 train plus gap", bz_last, 2 * 100 + 800);

        // Digit 0 gives ten pulses.
        clear_mon(); press(0); wait_idle();
        check("R3 pulses for 0", dp_rises, 10);

        // Burst: ten keys of 1 and an undefined code while busy.
        clear_mon();
        for (int i = 0; i < 10; i++) press(1);
        press(15);
        wait_idle();
        check("R10 overflow drop", dp_rises, 9);

        // Order: 3 then 2 back to back.
        clear_mon(); press(3); press(2); wait_idle();
        check("R10 queued order pulses", dp_rises, 5);

        // Recall keys and pause.
        clear_mon(); press(12); wait_idle();
        check_len("R5 short recall", dp_last, 100);
        clear_mon(); press(13); wait_idle();
        check_len("R5 long recall", dp_last, 600);
        clear_mon(); press(14); wait_idle();
        check_len("R6 pause busy", bz_last, 2000);
        check("R6 pause no line", dp_rises, 0);
        check("R11 hash in pulse mode", strobes, 0);

        // Star to tone, tone keys, recall back to pulse.
        clear_mon(); press(11); press(10); wait_idle();
        check("R11 hash discarded in pulse", strobes, 0);
        check("R7 star sets tone", int'(tone_mode), 1);
        check("R7 star no signalling", dp_rises + bz_last, 0);
        press(5); wait_idle();
        check("R11 strobe count", strobes, 1);
        check("R11 strobe code", last_code, 5);
        check_len("R11 tone slot", bz_last, 100);
        press(11); press(10); wait_idle();
        check("R11 hash and star strobes", strobes, 3);
        check("R11 last code star", last_code, 10);
        press(12); wait_idle();
        check("R5 recall reverts", int'(tone_mode), 0);
        clear_mon(); press(1); wait_idle();
        check("R5 pulse after revert", dp_rises, 1);

        // On-hook aborts and flushes.
        press(10); wait_idle();
        clear_mon(); press(14); press(4);
        repeat (200) @(negedge clk);
        off_hook = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R9 busy aborted", int'(busy), 0);
        check("R9 mode reverted", int'(tone_mode), 0);
        press(7);
        off_hook = 1'b1;
        repeat (600) @(negedge clk);
        check("R9 queue flushed", strobes + dp_rises, 0);
        check("R9 stays idle", int'(busy), 0);

        // Strap high.
        off_hook = 1'b0; strap_mode = 2'b01; repeat (2) @(negedge clk); off_hook = 1'b1;
        clear_mon(); press(3); wait_idle();
        check("R3 pulses strap high", dp_rises, 3);
        check_len("R2 break high", dp_last, 66);
        check_len("R2 make high", sh_last, 33);

        // Strap open: tone locked.
        off_hook = 1'b0; strap_mode = 2'b10; repeat (2) @(negedge clk); off_hook = 1'b1;
        @(negedge clk);
        check("R8 open strap tone", int'(tone_mode), 1);
        clear_mon(); press(12); wait_idle();
        check_len("R8 recall still breaks", dp_last, 100);
        check("R8 recall keeps tone", int'(tone_mode), 1);
        clear_mon(); press(2); wait_idle();
        check("R8 digit gives no pulse", dp_rises, 0);
        check("R8 digit strobed", last_code, 2);

        finish_run();
    end
endmodule